// File: doc/BRIEF.md
# System Bus Ownership Arbiter

This block decides, on every clock of the bus clock, which requester owns a shared system bus. The CPU owns the bus by default. Up to three local masters (sets 0, 1 and 2) request with active-low lines and get active-low grants. A DMA controller requests with a hold line and receives a grant. A hidden memory refresh request is not given ownership. Instead it gets a permit while the current owner keeps the bus. Before any other requester can own the bus, the arbiter raises a hold request to the CPU and waits for the CPU's acknowledge.

Class priority is fixed. DMA comes first, then refresh, then local masters, then the CPU. Among the local masters a rotating pointer decides the order, and the pointer starts at set 0. Set 0 is always enabled. Sets 1 and 2 each have an enable bit. When either of them is enabled, one extra synchronization clock is placed before each local grant. A DMA request takes the bus away from a local master: the master's grant is withdrawn, and the arbiter waits for that master to drop its request.

The controller is a single state machine with these states:
- ST_CPU: the CPU owns the bus.
- ST_HOLD: hold is raised and the next owner is being decided.
- ST_SYNC: the extra synchronization clock.
- ST_LOCAL: a local master is granted.
- ST_PREEMPT: the local grant is withdrawn and the arbiter waits for the request to drop.
- ST_DMA: DMA is granted.
- ST_RELEASE: hold is dropped and the arbiter waits for the acknowledge to fall.

The transitions are:
- ST_CPU to ST_HOLD, on a request.
- ST_HOLD to ST_DMA, ST_SYNC, ST_LOCAL or ST_RELEASE, once the acknowledge is seen.
- ST_SYNC to ST_LOCAL, or back to ST_HOLD if DMA arrives.
- ST_LOCAL to ST_PREEMPT on DMA, or to ST_HOLD on release.
- ST_PREEMPT to ST_DMA, or to ST_HOLD if DMA has vanished.
- ST_DMA to ST_HOLD when DMA drops.
- ST_RELEASE to ST_CPU.

Top module: `sysbus_arbiter`

## Requirements
- R1: After reset, and whenever `cpu_hold` is low, no local grant and no DMA grant is active. After reset, `cpu_hold` is low and `rfsh_ok` is low.
- R2: `cpu_hold` rises when the synchronized DMA request or an eligible local request is present. No grant is issued before `cpu_hlda` is high. `cpu_hold` falls once no requester remains.
- R3: When DMA and a local master are both pending at the decision point, DMA is granted.
- R4: A local grant goes to the first eligible requesting set, searching upward from the rotating pointer with wrap-around. After reset the pointer is set 0. Grant bit i of `lm_gnt_n` is low for set i.
- R5: When a local owner releases the bus, or is preempted, the pointer moves to the next-numbered enabled set after that owner.
- R6: A DMA request seen while a local master is granted removes that grant on the next clock. DMA is not granted until the owner's request line goes high.
- R7: Ownership passes between a local master and DMA, in either direction, without `cpu_hold` falling.
- R8: `dma_hreq` passes through SYNC_STAGES flip-flops. With the default of 2, `cpu_hold` is still low two clocks after `dma_hreq` rises and is high after the third.
- R9: `rfsh_ok` follows `rfsh_req` only in ST_CPU or ST_LOCAL, and only while no synchronized DMA request is present.
- R10: While `rfsh_req` is high under CPU ownership, a local request does not raise `cpu_hold`.
- R11: Count the clocks with `cpu_hold` high before a local grant appears, starting from CPU ownership. With only set 0 enabled the count is 2. With bit 0 or bit 1 of `lm_set_en` set (enabling set 1 or set 2), the count is 3.
- R12: At most one grant is active in any cycle. No grant is asserted in a cycle in which another grant is deasserted.
- R13: A disabled set never receives a grant. Its request alone does not raise `cpu_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lm_set_en | input | NUM_LM-1 | Enable for local sets 1 and up (bit 0 enables set 1) |
| lm_req_n | input | NUM_LM | Active-low local master requests |
| lm_gnt_n | output | NUM_LM | Active-low local master grants |
| cpu_hold | output | 1 | Hold request to the CPU |
| cpu_hlda | input | 1 | Hold acknowledge from the CPU |
| dma_hreq | input | 1 | DMA hold request, asynchronous |
| dma_grant | output | 1 | Bus grant to DMA |
| rfsh_req | input | 1 | Hidden refresh request |
| rfsh_ok | output | 1 | Hidden refresh permitted this cycle |

## Verification
The assertions check several properties on every cycle:
- Only one grant is active at a time.
- Grants never swap owners within a single cycle.
- A grant only rises while hold is acknowledged.
- Disabled sets are never granted.
- The refresh permit stays off when DMA is pending.
- A local grant is withdrawn one clock after a synchronized DMA request.

Other behaviour only the bench scenarios can show:
- The rotating order.
- Pointer movement past disabled sets.
- The exact synchronizer latency.
- The extra clock when several sets are enabled.
- DMA waiting for the preempted master to release.
- Refresh holding off a local master.
- Hand-offs that keep hold asserted.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [2:0] {
        ST_CPU,
        ST_HOLD,
        ST_SYNC,
        ST_LOCAL,
        ST_PREEMPT,
        ST_DMA,
        ST_RELEASE
    } arb_state_e;

endpackage

// File: rtl/sba_sync.sv
module sba_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[i] <= 1'b0;
                else        sr[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[i] <= 1'b0;
                else        sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];

endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int NUM = 3,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] cand,
    input  logic [IW-1:0]  start,
    output logic           hit,
    output logic [IW-1:0]  idx
);

    // Walk offsets from farthest to nearest so the nearest candidate wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int off = NUM - 1; off >= 0; off--) begin
            logic [IW-1:0] p;
            p = IW'((int'(start) + off) % NUM);
            if (cand[p]) begin
                hit = 1'b1;
                idx = p;
            end
        end
    end

endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
    import sba_pkg::*;
#(
    parameter int NUM_LM      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LM-2:0] lm_set_en,
    input  logic [NUM_LM-1:0] lm_req_n,
    output logic [NUM_LM-1:0] lm_gnt_n,
    output logic              cpu_hold,
    input  logic              cpu_hlda,
    input  logic              dma_hreq,
    output logic              dma_grant,
    input  logic              rfsh_req,
    output logic              rfsh_ok
);

    localparam int IW = (NUM_LM > 1) ? $clog2(NUM_LM) : 1;
    localparam logic [IW-1:0] LAST_SET = IW'(NUM_LM - 1);

    arb_state_e        state, state_nxt;
    logic [IW-1:0]     owner, owner_nxt;
    logic [IW-1:0]     rr_ptr, rr_ptr_nxt;
    logic [IW-1:0]     owner_inc;
    logic [NUM_LM-1:0] set_on;
    logic [NUM_LM-1:0] elig;
    logic              multi;
    logic              dma_s;
    logic              pick_hit, adv_hit;
    logic [IW-1:0]     pick_idx, adv_idx;
    logic [IW-1:0]     ptr_after;

    // Set 0 is always on; the others follow their enable bits.
    assign set_on    = {lm_set_en, 1'b1};
    assign elig      = set_on & ~lm_req_n;
    assign multi     = |lm_set_en;
    assign owner_inc = (owner == LAST_SET) ? '0 : owner + 1'b1;
    assign ptr_after = adv_hit ? adv_idx : '0;

    sba_sync #(.STAGES(SYNC_STAGES)) u_dma_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dma_hreq),
        .q     (dma_s)
    );

    // Next owner among requesting, enabled sets.
    sba_rr_pick #(.NUM(NUM_LM)) u_pick (
        .cand  (elig),
        .start (rr_ptr),
        .hit   (pick_hit),
        .idx   (pick_idx)
    );

    // Next enabled set after the current owner, for the pointer update.
    sba_rr_pick #(.NUM(NUM_LM)) u_adv (
        .cand  (set_on),
        .start (owner_inc),
        .hit   (adv_hit),
        .idx   (adv_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CPU;
            owner  <= '0;
            rr_ptr <= '0;
        end else begin
            state  <= state_nxt;
            owner  <= owner_nxt;
            rr_ptr <= rr_ptr_nxt;
        end
    end

    always_comb begin
        state_nxt  = state;
        owner_nxt  = owner;
        rr_ptr_nxt = rr_ptr;
        unique case (state)
            ST_CPU: begin
                if (dma_s || (pick_hit && !rfsh_req)) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cpu_hlda) begin
                    if (dma_s) begin
                        state_nxt = ST_DMA;
                    end else if (pick_hit) begin
                        owner_nxt = pick_idx;
                        state_nxt = multi ? ST_SYNC : ST_LOCAL;
                    end else begin
                        state_nxt = ST_RELEASE;
                    end
                end
            end
            ST_SYNC: begin
                state_nxt = dma_s ? ST_HOLD : ST_LOCAL;
            end
            ST_LOCAL: begin
                if (dma_s) begin
                    state_nxt = ST_PREEMPT;
                end else if (lm_req_n[owner]) begin
                    rr_ptr_nxt = ptr_after;
                    state_nxt  = ST_HOLD;
                end
            end
            ST_PREEMPT: begin
                if (lm_req_n[owner]) begin
                    rr_ptr_nxt = ptr_after;
                    state_nxt  = dma_s ? ST_DMA : ST_HOLD;
                end
            end
            ST_DMA: begin
                if (!dma_s) state_nxt = ST_HOLD;
            end
            ST_RELEASE: begin
                if (!cpu_hlda) state_nxt = ST_CPU;
            end
            default: state_nxt = ST_CPU;
        endcase
    end

    always_comb begin
        lm_gnt_n  = '1;
        dma_grant = 1'b0;
        cpu_hold  = 1'b1;
        rfsh_ok   = 1'b0;
        unique case (state)
            ST_CPU: begin
                cpu_hold = 1'b0;
                rfsh_ok  = rfsh_req && !dma_s;
            end
            ST_LOCAL: begin
                lm_gnt_n[owner] = 1'b0;
                rfsh_ok         = rfsh_req && !dma_s;
            end
            ST_DMA:     dma_grant = 1'b1;
            ST_RELEASE: cpu_hold  = 1'b0;
            default:    cpu_hold  = 1'b1;
        endcase
    end

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int NUM_LM = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_LM-2:0] lm_set_en,
    input logic [NUM_LM-1:0] lm_gnt_n,
    input logic              cpu_hold,
    input logic              cpu_hlda,
    input logic              dma_grant,
    input logic              rfsh_req,
    input logic              rfsh_ok,
    input logic              dma_s
);

    logic [NUM_LM:0] gvec;
    assign gvec = {dma_grant, ~lm_gnt_n};

    // R12
    a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gvec) <= 1);

    // R12
    a_r12_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(gvec) & ~gvec)) |-> ((gvec & ~$past(gvec)) == '0));

    // R2
    a_r2_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gvec) |-> (cpu_hold && cpu_hlda));

    // R1
    a_r1_cpu_owns_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hold |-> (gvec == '0));

    // R13
    a_r13_disabled_never: assert property (@(posedge clk) disable iff (!rst_n)
        ((~lm_gnt_n[NUM_LM-1:1]) & ~lm_set_en) == '0);

    // R9
    a_r9_refresh_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ok |-> (rfsh_req && !dma_grant && !dma_s));

    // R6
    a_r6_preempt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&lm_gnt_n) && dma_s) |=> (&lm_gnt_n));

endmodule

bind sysbus_arbiter sba_checker #(.NUM_LM(NUM_LM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lm_set_en (lm_set_en),
    .lm_gnt_n  (lm_gnt_n),
    .cpu_hold  (cpu_hold),
    .cpu_hlda  (cpu_hlda),
    .dma_grant (dma_grant),
    .rfsh_req  (rfsh_req),
    .rfsh_ok   (rfsh_ok),
    .dma_s     (dma_s)
);

// File: tb/sysbus_arbiter_tb_top.sv
module sysbus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] lm_set_en;
    logic [2:0] lm_req_n;
    logic [2:0] lm_gnt_n;
    logic       cpu_hold;
    logic       cpu_hlda;
    logic       dma_hreq;
    logic       dma_grant;
    logic       rfsh_req;
    logic       rfsh_ok;

    int checks = 0;
    int fails  = 0;
    int multi_err = 0;
    bit done = 0;
    bit watch = 0;
    bit hold_dropped = 0;

    // Fields: [7:6] set enables, [5:3] active-high requests, [2:0] expected grant mask
    localparam logic [7:0] VEC [7] = '{
        {2'b00, 3'b111, 3'b001},
        {2'b11, 3'b110, 3'b010},
        {2'b01, 3'b110, 3'b010},
        {2'b10, 3'b010, 3'b000},
        {2'b10, 3'b110, 3'b100},
        {2'b11, 3'b100, 3'b100},
        {2'b00, 3'b110, 3'b000}
    };

    always #5 clk = ~clk;

    sysbus_arbiter #(.NUM_LM(3), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lm_set_en (lm_set_en),
        .lm_req_n  (lm_req_n),
        .lm_gnt_n  (lm_gnt_n),
        .cpu_hold  (cpu_hold),
        .cpu_hlda  (cpu_hlda),
        .dma_hreq  (dma_hreq),
        .dma_grant (dma_grant),
        .rfsh_req  (rfsh_req),
        .rfsh_ok   (rfsh_ok)
    );

    // CPU model: acknowledges hold one clock later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_hlda <= 1'b0;
        else        cpu_hlda <= cpu_hold;
    end

    always @(negedge clk) begin
        if (rst_n && ($countones({dma_grant, ~lm_gnt_n}) > 1)) multi_err++;
        if (watch && !cpu_hold) hold_dropped = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lm_set_en = 2'b00;
        lm_req_n = 3'b111;
        dma_hreq = 1'b0;
        rfsh_req = 1'b0;
        watch = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_to_grant(output int cnt);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!lm_gnt_n[0]) break;
            if (cpu_hold) cnt++;
        end
    endtask

    initial begin
        repeat (6000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        do_reset();
        // R1 reset state
        check(cpu_hold == 1'b0, "R1", "cpu_hold after reset", cpu_hold, 0);
        check(lm_gnt_n == 3'b111, "R1", "grants after reset", lm_gnt_n, 7);
        check(dma_grant == 1'b0 && rfsh_ok == 1'b0, "R1", "dma/refresh after reset",
              {dma_grant, rfsh_ok}, 0);

        // R4 / R13 selection table
        for (int i = 0; i < 7; i++) begin
            do_reset();
            lm_set_en = VEC[i][7:6];
            lm_req_n  = ~VEC[i][5:3];
            wait_n(10);
            check(~lm_gnt_n == VEC[i][2:0], "R4", "table grant mask", ~lm_gnt_n, VEC[i][2:0]);
            if (VEC[i][2:0] == 3'b000)
                check(cpu_hold == 1'b0, "R13", "disabled request raised hold", cpu_hold, 0);
        end

        // R5 rotation 0 -> 1 -> 2 -> 0
        do_reset();
        lm_set_en = 2'b11;
        lm_req_n = 3'b000;
        wait_n(10);
        check(lm_gnt_n == 3'b110, "R4", "first grant set 0", lm_gnt_n, 6);
        lm_req_n[0] = 1'b1;
        wait_n(8);
        check(lm_gnt_n == 3'b101, "R5", "rotate to set 1", lm_gnt_n, 5);
        lm_req_n[1] = 1'b1;
        wait_n(8);
        check(lm_gnt_n == 3'b011, "R5", "rotate to set 2", lm_gnt_n, 3);
        lm_req_n = 3'b100;
        wait_n(8);
        check(lm_gnt_n == 3'b110, "R5", "wrap to set 0", lm_gnt_n, 6);

        // R5 / R13 pointer skips a disabled set
        do_reset();
        lm_set_en = 2'b10;
        lm_req_n = 3'b000;
        wait_n(10);
        check(lm_gnt_n == 3'b110, "R4", "set 0 first", lm_gnt_n, 6);
        lm_req_n[0] = 1'b1;
        wait_n(8);
        check(lm_gnt_n == 3'b011, "R5", "skip disabled set 1", lm_gnt_n, 3);
        lm_req_n[2] = 1'b1;
        wait_n(10);
        check(cpu_hold == 1'b0 && lm_gnt_n == 3'b111, "R13", "return to CPU with only disabled request",
              {cpu_hold, lm_gnt_n}, 7);

        // R11 synchronization clock
        do_reset();
        lm_req_n[0] = 1'b0;
        count_to_grant(cnt);
        check(cnt == 2, "R11", "hold cycles single set", cnt, 2);
        do_reset();
        lm_set_en = 2'b01;
        lm_req_n[0] = 1'b0;
        count_to_grant(cnt);
        check(cnt == 3, "R11", "hold cycles multi set", cnt, 3);

        // R8 DMA synchronizer latency, R2 hold handshake
        do_reset();
        dma_hreq = 1'b1;
        @(negedge clk);
        check(cpu_hold == 1'b0, "R8", "hold after 1 clock", cpu_hold, 0);
        @(negedge clk);
        check(cpu_hold == 1'b0, "R8", "hold after 2 clocks", cpu_hold, 0);
        @(negedge clk);
        check(cpu_hold == 1'b1, "R8", "hold after 3 clocks", cpu_hold, 1);
        check(dma_grant == 1'b0, "R2", "no grant before ack", dma_grant, 0);
        wait_n(4);
        check(dma_grant == 1'b1, "R2", "DMA granted after ack", dma_grant, 1);
        dma_hreq = 1'b0;
        wait_n(8);
        check(dma_grant == 1'b0 && cpu_hold == 1'b0, "R2", "hold released", {dma_grant, cpu_hold}, 0);

        // R3 DMA wins over simultaneous local request
        do_reset();
        dma_hreq = 1'b1;
        lm_req_n[0] = 1'b0;
        wait_n(8);
        check(dma_grant == 1'b1 && lm_gnt_n == 3'b111, "R3", "DMA beats local",
              {dma_grant, lm_gnt_n}, 15);

        // R6 preemption, R7 direct hand-off
        do_reset();
        lm_set_en = 2'b01;
        lm_req_n = 3'b100;
        wait_n(8);
        check(lm_gnt_n == 3'b110, "R6", "set 0 owns", lm_gnt_n, 6);
        watch = 1'b1;
        hold_dropped = 1'b0;
        dma_hreq = 1'b1;
        wait_n(5);
        check(lm_gnt_n == 3'b111 && dma_grant == 1'b0, "R6", "grant withdrawn",
              {dma_grant, lm_gnt_n}, 7);
        wait_n(10);
        check(dma_grant == 1'b0, "R6", "DMA waits for request drop", dma_grant, 0);
        lm_req_n[0] = 1'b1;
        wait_n(3);
        check(dma_grant == 1'b1, "R6", "DMA after release", dma_grant, 1);
        dma_hreq = 1'b0;
        wait_n(8);
        check(lm_gnt_n == 3'b101, "R7", "DMA to set 1", lm_gnt_n, 5);
        check(hold_dropped == 1'b0, "R7", "hold stayed high", hold_dropped, 0);
        watch = 1'b0;

        // R9 / R10 refresh
        do_reset();
        rfsh_req = 1'b1;
        @(negedge clk);
        check(rfsh_ok == 1'b1, "R9", "refresh under CPU", rfsh_ok, 1);
        lm_req_n[0] = 1'b0;
        wait_n(8);
        check(cpu_hold == 1'b0 && lm_gnt_n == 3'b111, "R10", "refresh defers local",
              {cpu_hold, lm_gnt_n}, 7);
        rfsh_req = 1'b0;
        wait_n(8);
        check(lm_gnt_n == 3'b110, "R10", "local after refresh", lm_gnt_n, 6);
        rfsh_req = 1'b1;
        @(negedge clk);
        check(rfsh_ok == 1'b1, "R9", "refresh under local", rfsh_ok, 1);
        dma_hreq = 1'b1;
        lm_req_n[0] = 1'b1;
        wait_n(3);
        check(rfsh_ok == 1'b0, "R9", "refresh blocked by pending DMA", rfsh_ok, 0);
        wait_n(12);
        check(dma_grant == 1'b1 && rfsh_ok == 1'b0, "R9", "refresh blocked under DMA",
              {dma_grant, rfsh_ok}, 2);
        dma_hreq = 1'b0;
        wait_n(10);
        check(rfsh_ok == 1'b1, "R9", "refresh back under CPU", rfsh_ok, 1);

        check(multi_err == 0, "R12", "cycles with multiple grants", multi_err, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule